// File: doc/BRIEF.md
# Host Buffer Access Port

This block gives a host CPU a single data port through which it fills a packet transmit buffer and empties a packet receive buffer. The two directions never share storage. A host write always lands in a small transmit FIFO, and a host read always takes data from a small receive FIFO. Because of this, the host needs no direction control and can mix transmit writes and receive reads in any order. Behind each FIFO sits a buffer memory whose read and write pointers the block advances on its own. The host never writes a pointer.

The port becomes visible in two ways. The first is a strobed access at register offset 8 while the bank-select field from the control register reads 2'b10. The second is any strobed access while the DMA acknowledge input is high; in that case the bank-select field and the address are ignored. A width-mode input picks the access width. In byte mode each access moves the low 8 bits. In word mode each access moves 16 bits, and an access flagged as a byte-lane access is refused with an error flag. The MAC side reads transmit words and writes receive words through plain pop/push ports.

Top module: `host_buf_port`

## Requirements
- R1: The port is hit only when `cs_i` is high, `bank_sel_i` is 2'b10 and `addr_i` is 8. For other bank or address values, with `dmack_i` low, nothing is stored or removed and `rdy_o` and `err_o` stay 0.
- R2: When `dmack_i` and `cs_i` are high, the port is hit whatever `bank_sel_i` and `addr_i` hold.
- R3: Host writes (`we_i`=1) feed only the transmit path and host reads (`we_i`=0) draw only from the receive path. Interleaving them keeps the order within each direction.
- R4: Both buffer memories advance their pointers by one per word and wrap at `MEM_DEPTH`. First-in first-out order is kept across the wrap.
- R5: In byte mode (`word_mode_i`=0), a write stores `wdata_i[7:0]` with the upper bits zero. A read returns the stored low byte on `rdata_o[7:0]` with the upper bits zero, and `byte_acc_i` is ignored.
- R6: In word mode, a hit with `byte_acc_i`=1 gives `rdy_o`=1, `err_o`=1 and `rdata_o`=0, and it neither stores nor removes a word.
- R7: The transmit FIFO moves one word per clock into the transmit memory while that memory is not full. A host write with the FIFO full gets `rdy_o`=0 and is not stored.
- R8: A host read while the receive FIFO is empty gets `rdy_o`=0 and removes nothing. Once a word reaches the FIFO, the next read gets `rdy_o`=1 and that word.
- R9: When the receive memory is full, `mac_rx_full_o` is 1 and a MAC receive write is dropped.
- R10: After reset, `rdy_o`, `err_o`, `rdata_o`, `mac_tx_valid_o` and `mac_rx_full_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Host access strobe, one access per cycle |
| we_i | input | 1 | 1 = write (transmit), 0 = read (receive) |
| addr_i | input | ADDR_W | Host register offset |
| bank_sel_i | input | 2 | Register bank-select field |
| dmack_i | input | 1 | DMA acknowledge; forces port selection |
| word_mode_i | input | 1 | 1 = 16-bit accesses, 0 = 8-bit accesses |
| byte_acc_i | input | 1 | Access uses a single byte lane |
| wdata_i | input | DATA_W | Host write data |
| rdata_o | output | DATA_W | Host read data, valid when rdy_o is high on a read |
| rdy_o | output | 1 | Access completes this cycle |
| err_o | output | 1 | Refused byte-lane access in word mode |
| mac_tx_rd_i | input | 1 | MAC pops one transmit word |
| mac_tx_data_o | output | DATA_W | Oldest transmit-memory word |
| mac_tx_valid_o | output | 1 | Transmit memory holds data |
| mac_rx_wr_i | input | 1 | MAC pushes one receive word |
| mac_rx_data_i | input | DATA_W | Receive word from the MAC |
| mac_rx_full_o | output | 1 | Receive memory full |

## Verification
The bench builds the block with `MEM_DEPTH` set to 8 and the FIFO depths left at 4, so each direction holds only 12 words. With that size, a short run can fill the transmit path until writes stall and fill the receive path until MAC writes drop. It can also drive both memory pointers past their wrap point more than once. The decode table covers the bank-select and DMA acknowledge paths and both width modes before the directed fill, drain, stall and refusal sequences.

// File: rtl/hbp_pkg.sv
package hbp_pkg;
  typedef enum logic [1:0] {ACC_NONE, ACC_WR, ACC_RD, ACC_BAD} acc_e;
  localparam logic [1:0] BANK_BUF = 2'b10;
endpackage

// File: rtl/hbp_decode.sv
module hbp_decode
  import hbp_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int PORT_OFF = 8
) (
  input  logic              cs_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        bank_sel_i,
  input  logic              dmack_i,
  input  logic              word_mode_i,
  input  logic              byte_acc_i,
  output acc_e              acc_o
);
  logic hit;

  // DMA acknowledge overrides bank and offset decode
  assign hit = cs_i & (dmack_i | ((bank_sel_i == BANK_BUF) &&
                                  (addr_i == ADDR_W'(PORT_OFF))));

  always_comb begin
    if (!hit)                           acc_o = ACC_NONE;
    else if (word_mode_i && byte_acc_i) acc_o = ACC_BAD;
    else if (we_i)                      acc_o = ACC_WR;
    else                                acc_o = ACC_RD;
  end
endmodule

// File: rtl/hbp_fifo.sv
module hbp_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wp_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wp_q <= step(wp_q);
      if (pop_i)  rp_q <= step(rp_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign dout_o  = mem_q[rp_q];
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);

  // R7
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_i && full_o));
  // R8
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/hbp_ring.sv
module hbp_ring #(
  parameter int W     = 16,
  parameter int DEPTH = 256
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         rd_i,
  output logic [W-1:0] rdata_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem_q [DEPTH];
  logic [AW:0]  wp_q, rp_q;   // extra bit tells full from empty

  always_ff @(posedge clk_i) begin
    if (wr_i) mem_q[wp_q[AW-1:0]] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      if (wr_i) wp_q <= wp_q + 1'b1;
      if (rd_i) rp_q <= rp_q + 1'b1;
    end
  end

  assign rdata_o = mem_q[rp_q[AW-1:0]];
  assign empty_o = (wp_q == rp_q);
  assign full_o  = (wp_q[AW] != rp_q[AW]) && (wp_q[AW-1:0] == rp_q[AW-1:0]);

  // R9
  ring_no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && full_o));
  // R4
  ptr_advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> (rp_q == $past(rp_q) + 1'b1));
endmodule

// File: rtl/host_buf_port.sv
module host_buf_port
  import hbp_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 4,
  parameter int PORT_OFF = 8,
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 4,
  parameter int MEM_DEPTH = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        bank_sel_i,
  input  logic              dmack_i,
  input  logic              word_mode_i,
  input  logic              byte_acc_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdy_o,
  output logic              err_o,
  input  logic              mac_tx_rd_i,
  output logic [DATA_W-1:0] mac_tx_data_o,
  output logic              mac_tx_valid_o,
  input  logic              mac_rx_wr_i,
  input  logic [DATA_W-1:0] mac_rx_data_i,
  output logic              mac_rx_full_o
);
  localparam int LANE_W = 8;

  acc_e              acc;
  logic              tx_push, tx_full, tx_empty, tx_mv;
  logic              rx_pop, rx_full, rx_empty, rx_mv;
  logic              txm_full, txm_empty, rxm_full, rxm_empty;
  logic [DATA_W-1:0] host_wdata, tx_head, rx_head, rxm_head;

  hbp_decode #(.ADDR_W(ADDR_W), .PORT_OFF(PORT_OFF)) i_dec (
    .cs_i, .we_i, .addr_i, .bank_sel_i, .dmack_i, .word_mode_i, .byte_acc_i,
    .acc_o(acc)
  );

  // byte mode carries only the low lane
  assign host_wdata = word_mode_i ? wdata_i
                    : {{(DATA_W-LANE_W){1'b0}}, wdata_i[LANE_W-1:0]};

  assign tx_push = (acc == ACC_WR) && !tx_full;
  assign rx_pop  = (acc == ACC_RD) && !rx_empty;
  assign rdy_o   = tx_push | rx_pop | (acc == ACC_BAD);
  assign err_o   = (acc == ACC_BAD);

  always_comb begin
    rdata_o = '0;
    if (rx_pop)
      rdata_o = word_mode_i ? rx_head
              : {{(DATA_W-LANE_W){1'b0}}, rx_head[LANE_W-1:0]};
  end

  assign tx_mv = !tx_empty && !txm_full;
  assign rx_mv = !rxm_empty && !rx_full;

  hbp_fifo #(.W(DATA_W), .DEPTH(TX_DEPTH)) i_tx_fifo (
    .clk_i, .rst_ni, .push_i(tx_push), .din_i(host_wdata), .pop_i(tx_mv),
    .dout_o(tx_head), .full_o(tx_full), .empty_o(tx_empty)
  );

  hbp_ring #(.W(DATA_W), .DEPTH(MEM_DEPTH)) i_tx_mem (
    .clk_i, .rst_ni, .wr_i(tx_mv), .wdata_i(tx_head),
    .rd_i(mac_tx_rd_i && !txm_empty), .rdata_o(mac_tx_data_o),
    .full_o(txm_full), .empty_o(txm_empty)
  );

  hbp_ring #(.W(DATA_W), .DEPTH(MEM_DEPTH)) i_rx_mem (
    .clk_i, .rst_ni, .wr_i(mac_rx_wr_i && !rxm_full), .wdata_i(mac_rx_data_i),
    .rd_i(rx_mv), .rdata_o(rxm_head), .full_o(rxm_full), .empty_o(rxm_empty)
  );

  hbp_fifo #(.W(DATA_W), .DEPTH(RX_DEPTH)) i_rx_fifo (
    .clk_i, .rst_ni, .push_i(rx_mv), .din_i(rxm_head), .pop_i(rx_pop),
    .dout_o(rx_head), .full_o(rx_full), .empty_o(rx_empty)
  );

  assign mac_tx_valid_o = !txm_empty;
  assign mac_rx_full_o  = rxm_full;

  // R6
  bad_acc_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!tx_push && !rx_pop && rdata_o == '0));
  // R1
  idle_no_rdy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_i |-> (!rdy_o && !err_o));
  // R7
  tx_drain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_empty && !txm_full) |=> !txm_empty);
endmodule

// File: tb/test_host_buf_port.sv
module test_host_buf_port;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cs = 1'b0, we = 1'b0, dmack = 1'b0, word = 1'b1, bacc = 1'b0;
  logic [3:0]    addr = '0;
  logic [1:0]    bank = '0;
  logic [DW-1:0] wdata = '0, rdata, tx_data, rx_wdata = '0;
  logic          rdy, err, tx_rd = 1'b0, tx_valid, rx_wr = 1'b0, rx_full;

  int n_chk = 0, n_fail = 0;
  logic          s_rdy, s_err;
  logic [DW-1:0] s_rdata;

  always #2.5 clk = ~clk;

  host_buf_port #(.MEM_DEPTH(8)) i_host_buf_port (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .we_i(we), .addr_i(addr),
    .bank_sel_i(bank), .dmack_i(dmack), .word_mode_i(word), .byte_acc_i(bacc),
    .wdata_i(wdata), .rdata_o(rdata), .rdy_o(rdy), .err_o(err),
    .mac_tx_rd_i(tx_rd), .mac_tx_data_o(tx_data), .mac_tx_valid_o(tx_valid),
    .mac_rx_wr_i(rx_wr), .mac_rx_data_i(rx_wdata), .mac_rx_full_o(rx_full)
  );

  // {bank, addr, dmack, word, bacc, take, err, 5'b0, wdata}
  function automatic logic [31:0] mk(input logic [1:0] b, input logic [3:0] a,
      input logic d, w, y, t, e, input logic [15:0] v);
    return {b, a, d, w, y, t, e, 5'b0, v};
  endfunction

  localparam logic [31:0] TBL [8] = '{
    mk(2'b10, 4'd8, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 16'hA1B2),  // R1 hit
    mk(2'b01, 4'd8, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h1111),  // R1 bank miss
    mk(2'b10, 4'd9, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h2222),  // R1 addr miss
    mk(2'b11, 4'd0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 16'hC3D4),  // R2
    mk(2'b00, 4'd5, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 16'h5E6F),  // R2
    mk(2'b10, 4'd8, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 16'h1234),  // R5
    mk(2'b10, 4'd8, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 16'h3333),  // R6
    mk(2'b10, 4'd8, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 16'hABCD)   // R5 lane flag ignored
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host(input logic w, input logic [1:0] b, input logic [3:0] a,
                      input logic d, input logic y, input logic [DW-1:0] v);
    cs = 1'b1; we = w; bank = b; addr = a; dmack = d; bacc = y; wdata = v;
    #1;
    s_rdy = rdy; s_err = err; s_rdata = rdata;
    @(posedge clk);
    @(negedge clk);
    cs = 1'b0; dmack = 1'b0; bacc = 1'b0;
  endtask

  task automatic hwr(input logic [DW-1:0] v);
    host(1'b1, 2'b10, 4'd8, 1'b0, 1'b0, v);
  endtask

  task automatic hrd();
    host(1'b0, 2'b10, 4'd8, 1'b0, 1'b0, '0);
  endtask

  task automatic mac_wr(input logic [DW-1:0] v);
    rx_wr = 1'b1; rx_wdata = v;
    @(posedge clk);
    @(negedge clk);
    rx_wr = 1'b0;
  endtask

  task automatic mac_rd(input string req, input logic [DW-1:0] exp);
    #1;
    chk(req, "tx valid", 32'(tx_valid), 32'd1);
    chk(req, "tx data", 32'(tx_data), 32'(exp));
    tx_rd = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tx_rd = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle(2);
    #1;
    // R10 reset state
    chk("R10", "rdy", 32'(rdy), 0);
    chk("R10", "err", 32'(err), 0);
    chk("R10", "rdata", 32'(rdata), 0);
    chk("R10", "tx valid", 32'(tx_valid), 0);
    chk("R10", "rx full", 32'(rx_full), 0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(1);

    // decode table walk
    for (int i = 0; i < 8; i++) begin
      logic [31:0] e;
      logic [DW-1:0] exp_d;
      e = TBL[i];
      word = e[24];
      host(1'b1, e[31:30], e[29:26], e[25], e[23], e[15:0]);
      chk("R1/R2 tbl", "rdy", 32'(s_rdy), 32'(e[22] | e[21]));
      chk("R6 tbl", "err", 32'(s_err), 32'(e[21]));
      idle(3);
      #1;
      chk("R1/R2 tbl", "tx valid", 32'(tx_valid), 32'(e[22]));
      if (e[22]) begin
        exp_d = e[24] ? e[15:0] : {8'h00, e[7:0]};
        mac_rd("R5 tbl", exp_d);
      end
    end
    word = 1'b1;

    // R8 read stall on empty receive path
    hrd();
    chk("R8", "rdy empty", 32'(s_rdy), 0);
    mac_wr(16'h5A5A);
    hrd();
    chk("R8", "rdy before fill", 32'(s_rdy), 0);
    hrd();
    chk("R8", "rdy after fill", 32'(s_rdy), 1);
    chk("R8", "rdata", 32'(s_rdata), 32'h5A5A);

    // R3 interleaved directions
    for (int i = 0; i < 3; i++) mac_wr(16'h7000 + 16'(i));
    idle(2);
    for (int i = 0; i < 3; i++) begin
      hwr(16'h3000 + 16'(i));
      chk("R3", "wr rdy", 32'(s_rdy), 1);
      hrd();
      chk("R3", "rd data", 32'(s_rdata), 32'h7000 + 32'(i));
    end
    idle(2);
    for (int i = 0; i < 3; i++) mac_rd("R3", 16'h3000 + 16'(i));

    // R7 R4 fill transmit path, stall, drain across wrap
    for (int i = 0; i < 12; i++) begin
      hwr(16'h4000 + 16'(i));
      chk("R7", "fill rdy", 32'(s_rdy), 1);
    end
    hwr(16'h4FFF);
    chk("R7", "stall rdy", 32'(s_rdy), 0);
    for (int i = 0; i < 12; i++) mac_rd("R4", 16'h4000 + 16'(i));
    #1;
    chk("R7", "dropped write absent", 32'(tx_valid), 0);

    // R9 fill receive path, drop extra
    idle(1);
    for (int i = 0; i < 12; i++) mac_wr(16'h6000 + 16'(i));
    #1;
    chk("R9", "rx full", 32'(rx_full), 1);
    @(negedge clk);
    mac_wr(16'h6FFF);
    for (int i = 0; i < 12; i++) begin
      hrd();
      chk("R4", "rx order", 32'(s_rdata), 32'h6000 + 32'(i));
    end
    hrd();
    chk("R9", "extra dropped", 32'(s_rdy), 0);

    // R6 refused byte-lane read keeps data
    mac_wr(16'h0077);
    idle(2);
    host(1'b0, 2'b10, 4'd8, 1'b0, 1'b1, '0);
    chk("R6", "rdy", 32'(s_rdy), 1);
    chk("R6", "err", 32'(s_err), 1);
    chk("R6", "rdata", 32'(s_rdata), 0);
    hrd();
    chk("R6", "word kept", 32'(s_rdata), 32'h0077);

    // R5 byte-mode read
    mac_wr(16'hBEEF);
    idle(2);
    word = 1'b0;
    hrd();
    chk("R5", "byte rdata", 32'(s_rdata), 32'h00EF);
    word = 1'b1;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule